// File: doc/BRIEF.md
# Burst Write CRC with Data Bus Inversion

This block prepares one write burst for a byte-wide memory data path: eight DQ lanes over eight beats, plus one data-bus-inversion lane. For each beat it decides whether the beat is driven inverted. It then produces the 8-bit CRC that the memory checks against the data as it appears on the pins, that is, the encoded DQ bits together with the inversion lane. The CRC byte is sent as the extra transfer after the final data beat.

The CRC is not built by running a shift register over the encoded burst. The raw burst is reduced into a base CRC while the per-beat inversion decisions are still being made, with every inversion lane taken as 0. A correction per beat is then folded in. That correction uses two constants, which are the parity of the beat's DQ contribution to each CRC bit and the inversion lane's own contribution, both selected by the beat's actual decision. Because the checksum is linear, the result equals the serial checksum of the encoded stream. The correction adds only a short XOR tail after the base reduction.

A single-cycle `start` strobe presents the 64 raw bits. All results are registered and appear with `valid` on the next cycle. They are held until the next strobe.

Top module: `wcd_top`

## Requirements
- R1: A beat is inverted exactly when more than half of its DQ bits (more than 4 of 8) are zero. A beat with exactly 4 zeros is not inverted.
- R2: Raw input bit `data_in[8k+j]` is DQ lane j of beat k. The matching bit of `enc_out` equals the raw bit complemented when beat k is inverted, and equals the raw bit unchanged otherwise.
- R3: The inversion lane is active low. `dbi_n_out[k]` is 0 for an inverted beat and 1 for a beat passed through.
- R4: `crc_out` uses the polynomial x^8+x^2+x+1 (0x07). The register starts at zero and is shifted MSB-first with input feedback. The stream is fed in this order: beat 0 DQ0..DQ7, then beat 0's `dbi_n_out` bit, then beat 1 in the same way, through to beat 7. The stream uses the encoded values, 72 bits in all.
- R5: An all-zero raw burst gives every beat inverted: `enc_out` is all ones, `dbi_n_out` is 0x00, and the CRC follows R4 over that stream. An all-ones burst is passed through unchanged with `dbi_n_out` equal to 0xFF.
- R6: `valid` is high in exactly the cycle after a cycle with `start` high, and low otherwise.
- R7: Without `start`, `enc_out`, `dbi_n_out` and `crc_out` keep their values, whatever `data_in` does.
- R8: While `rst` is high at a clock edge, all outputs are cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for `data_in` |
| data_in | input | 64 | Raw burst, beat k in bits [8k+7:8k] |
| enc_out | output | 64 | Encoded burst, same layout |
| dbi_n_out | output | 8 | Active-low inversion lane, bit k for beat k |
| crc_out | output | 8 | Checksum byte for the transfer after the burst |
| valid | output | 1 | Results updated in this cycle |

## Verification
A wrong inversion decision appears on the cycle after `start` in three places at once: the beat's `dbi_n_out` bit, all eight lanes of that beat, and the CRC, since the correction term is chosen from the decision. A wrong correction constant or base-tree coefficient leaves the encoded data correct but gives a CRC that disagrees with a bit-serial reference of the encoded stream. This shows on the first burst whose bit pattern touches that coefficient. Boundary patterns with exactly four and five zeros per beat, together with all-zero, all-ones and random bursts, expose both kinds of fault within one result cycle.

// File: rtl/wcd_pkg.sv
package wcd_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  typedef logic [CRC_W-1:0] crc_t;

  // Checksum contribution of a single '1' placed at stream position pos
  // in a zero-initialised stream of total bits.
  function automatic crc_t unit_term(int pos, int total, crc_t poly);
    crc_t c;
    c = poly;
    for (int s = pos + 1; s < total; s++)
      c = {c[CRC_W-2:0], 1'b0} ^ (c[CRC_W-1] ? poly : '0);
    return c;
  endfunction

  // XOR of the contributions of all DQ lanes of one beat.
  function automatic crc_t lane_parity(int beat, int lanes, int total, crc_t poly);
    crc_t m;
    m = '0;
    for (int j = 0; j < lanes; j++)
      m ^= unit_term(beat * (lanes + 1) + j, total, poly);
    return m;
  endfunction
endpackage

// File: rtl/wcd_dbi_decide.sv
module wcd_dbi_decide #(
  parameter int LANES = 8,
  parameter int BEATS = 8
) (
  input  logic [LANES*BEATS-1:0] raw,
  output logic [BEATS-1:0]       inv,
  output logic [LANES*BEATS-1:0] enc
);
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int HALF  = LANES / 2;

  for (genvar k = 0; k < BEATS; k++) begin : g_beat
    logic [CNT_W-1:0] zeros;
    always_comb begin
      zeros = '0;
      for (int j = 0; j < LANES; j++)
        zeros += CNT_W'(!raw[k*LANES+j]);
    end
    assign inv[k] = (zeros > CNT_W'(HALF));
    assign enc[k*LANES +: LANES] = raw[k*LANES +: LANES] ^ {LANES{inv[k]}};
  end
endmodule

// File: rtl/wcd_crc_base.sv
module wcd_crc_base
  import wcd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BEATS = 8
) (
  input  logic [LANES*BEATS-1:0] raw,
  output crc_t                   base
);
  localparam int TOTAL = BEATS * (LANES + 1);

  // Per-beat partial sums first, then the combine across beats; the
  // inversion lane is taken as 0, so it contributes nothing here.
  crc_t part [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_part
    always_comb begin
      part[k] = '0;
      for (int j = 0; j < LANES; j++)
        if (raw[k*LANES+j])
          part[k] ^= unit_term(k*(LANES+1)+j, TOTAL, CRC_POLY);
    end
  end

  always_comb begin
    base = '0;
    for (int k = 0; k < BEATS; k++)
      base ^= part[k];
  end
endmodule

// File: rtl/wcd_crc_fix.sv
module wcd_crc_fix
  import wcd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BEATS = 8
) (
  input  crc_t             base,
  input  logic [BEATS-1:0] inv,
  output crc_t             fixed
);
  localparam int TOTAL = BEATS * (LANES + 1);

  crc_t term [BEATS];

  // An inverted beat flips the lane-parity bits. A passed beat drives its
  // active-low inversion lane high, which adds that lane's own contribution.
  for (genvar k = 0; k < BEATS; k++) begin : g_term
    localparam crc_t PAR_M = lane_parity(k, LANES, TOTAL, CRC_POLY);
    localparam crc_t DBI_M = unit_term(k*(LANES+1)+LANES, TOTAL, CRC_POLY);
    assign term[k] = inv[k] ? PAR_M : DBI_M;
  end

  always_comb begin
    fixed = base;
    for (int k = 0; k < BEATS; k++)
      fixed ^= term[k];
  end
endmodule

// File: rtl/wcd_top.sv
module wcd_top
  import wcd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BEATS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [LANES*BEATS-1:0] data_in,
  output logic [LANES*BEATS-1:0] enc_out,
  output logic [BEATS-1:0]       dbi_n_out,
  output logic [CRC_W-1:0]       crc_out,
  output logic                   valid
);
  logic [BEATS-1:0]       inv;
  logic [LANES*BEATS-1:0] enc;
  crc_t                   base;
  crc_t                   fixed;

  wcd_dbi_decide #(.LANES(LANES), .BEATS(BEATS)) u_dec (
    .raw (data_in),
    .inv (inv),
    .enc (enc)
  );

  wcd_crc_base #(.LANES(LANES), .BEATS(BEATS)) u_base (
    .raw  (data_in),
    .base (base)
  );

  wcd_crc_fix #(.LANES(LANES), .BEATS(BEATS)) u_fix (
    .base  (base),
    .inv   (inv),
    .fixed (fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_out   <= '0;
      dbi_n_out <= '0;
      crc_out   <= '0;
      valid     <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        enc_out   <= enc;
        dbi_n_out <= ~inv;
        crc_out   <= fixed;
      end
    end
  end
endmodule

// File: rtl/wcd_check.sv
module wcd_check
  import wcd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BEATS = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic [LANES*BEATS-1:0] data_in,
  input logic [LANES*BEATS-1:0] enc_out,
  input logic [BEATS-1:0]       dbi_n_out,
  input logic [CRC_W-1:0]       crc_out,
  input logic                   valid
);
  crc_t serial;
  logic bit_in;
  logic fb;

  always_comb begin
    serial = '0;
    bit_in = 1'b0;
    fb     = 1'b0;
    for (int k = 0; k < BEATS; k++)
      for (int j = 0; j <= LANES; j++) begin
        bit_in = (j < LANES) ? enc_out[k*LANES+j] : dbi_n_out[k];
        fb     = serial[CRC_W-1] ^ bit_in;
        serial = {serial[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> valid); // R6
  AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (rst) !start |=> !valid); // R6
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(enc_out) && $stable(dbi_n_out) && $stable(crc_out))); // R7
  AST_CRC_SERIAL_MATCH: assert property (@(posedge clk) disable iff (rst) valid |-> (crc_out == serial)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!valid && crc_out == '0 && dbi_n_out == '0)); // R8

  for (genvar k = 0; k < BEATS; k++) begin : g_chk
    AST_INVERT_RULE: assert property (@(posedge clk) disable iff (rst)
      start |=> (dbi_n_out[k] == ($countones($past(data_in[k*LANES +: LANES])) >= (LANES - LANES/2)))); // R1
    AST_BEAT_ENCODING: assert property (@(posedge clk) disable iff (rst)
      start |=> (enc_out[k*LANES +: LANES] ==
                 (dbi_n_out[k] ? $past(data_in[k*LANES +: LANES]) : ~$past(data_in[k*LANES +: LANES])))); // R2
  end
endmodule

bind wcd_top wcd_check #(.LANES(LANES), .BEATS(BEATS)) u_wcd_check (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .data_in   (data_in),
  .enc_out   (enc_out),
  .dbi_n_out (dbi_n_out),
  .crc_out   (crc_out),
  .valid     (valid)
);

// File: tb/tb_wcd_top.sv
module tb_wcd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] data_in = '0;
  logic [63:0] enc_out;
  logic [7:0]  dbi_n_out;
  logic [7:0]  crc_out;
  logic        valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  wcd_top dut (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .enc_out(enc_out), .dbi_n_out(dbi_n_out), .crc_out(crc_out), .valid(valid)
  );

  localparam int NVEC = 10;
  localparam logic [63:0] STIM [NVEC] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0F0F_0F0F_0F0F_0F0F,
    64'h0707_0707_0707_0707,
    64'h0F07_F0E0_3C18_8001,
    64'h0102_0408_1020_4080,
    64'hDEAD_BEEF_0123_4567,
    64'h00FF_00FF_1E1F_7FFE,
    64'hA5A5_5A5A_C3C3_0000,
    64'h0000_0001_0000_8000
  };

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_model(input logic [63:0] d, output logic [63:0] e,
                                    output logic [7:0] dn, output logic [7:0] c);
    logic [7:0] b;
    int z;
    logic fbit;
    for (int k = 0; k < 8; k++) begin
      b = d[k*8 +: 8];
      z = 0;
      for (int j = 0; j < 8; j++) if (!b[j]) z++;
      dn[k] = !(z > 4);
      e[k*8 +: 8] = dn[k] ? b : ~b;
    end
    c = 8'h00;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 9; j++) begin
        fbit = c[7] ^ ((j < 8) ? e[k*8+j] : dn[k]);
        c = {c[6:0], 1'b0};
        if (fbit) c = c ^ 8'h07;
      end
  endfunction

  task automatic send(logic [63:0] d, string tag);
    logic [63:0] e;
    logic [7:0]  dn, c;
    ref_model(d, e, dn, c);
    @(negedge clk);
    data_in = d;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    data_in = ~d;
    chk(valid === 1'b1, {"R6 valid after start ", tag}, 64'(valid), 64'd1);
    chk(enc_out === e, {"R2 encoded beats ", tag}, enc_out, e);
    chk(dbi_n_out === dn, {"R1 R3 inversion lane ", tag}, 64'(dbi_n_out), 64'(dn));
    chk(crc_out === c, {"R4 crc ", tag}, 64'(crc_out), 64'(c));
    @(negedge clk);
    chk(valid === 1'b0, {"R6 valid single cycle ", tag}, 64'(valid), 64'd0);
    chk(enc_out === e && crc_out === c && dbi_n_out === dn, {"R7 hold ", tag},
        64'(crc_out), 64'(c));
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid === 1'b0 && enc_out === '0 && crc_out === '0 && dbi_n_out === '0,
        "R8 reset state", 64'(crc_out), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) send(STIM[i], $sformatf("vec%0d", i));

    begin
      logic [63:0] e;
      logic [7:0] dn, c;
      ref_model(64'd0, e, dn, c);
      send(64'd0, "R5 all-zero");
      chk(enc_out === {64{1'b1}} && dbi_n_out === 8'h00 && crc_out === c,
          "R5 all-zero burst inverted", enc_out, {64{1'b1}});
      send({64{1'b1}}, "R5 all-ones");
      chk(enc_out === {64{1'b1}} && dbi_n_out === 8'hFF,
          "R5 all-ones burst passed", 64'(dbi_n_out), 64'hFF);
    end

    send(64'h0F0F_0F0F_0F0F_0F0F, "R1 four zeros");
    chk(dbi_n_out === 8'hFF, "R1 exactly four zeros not inverted", 64'(dbi_n_out), 64'hFF);
    send(64'h0707_0707_0707_0707, "R1 five zeros");
    chk(dbi_n_out === 8'h00, "R1 five zeros inverted", 64'(dbi_n_out), 64'h00);

    for (int i = 0; i < 40; i++) send({$urandom(), $urandom()}, $sformatf("rnd%0d", i));

    send(64'h1234_5678_9ABC_DEF0, "pre-reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && crc_out === '0 && enc_out === '0 && dbi_n_out === '0,
        "R8 reset clears outputs", enc_out, 64'd0);
    rst = 1'b0;
    send(64'hFEDC_BA98_7654_3210, "post-reset");

    done = 1'b1;
    report();
  end
endmodule